// File: doc/BRIEF.md
# Switch-Replica Majority Voter

This block settles one data word that reaches a receiver as up to three copies within a single communication cycle, each copy carried by a different redundant network switch. Any switch may drop its copy, and a faulty sender may put different words on different switches. At the end of the receive window the block gives either one agreed word or an explicit statement that no agreement exists. Every receiver that sees the same set of copies reaches the same decision, because the result depends only on those copies.

Each lane has a valid strobe and a data word. The first word seen on a lane in a window is kept, and later ones on that lane are dropped. A one-cycle close strobe ends the window. A lane that stayed silent is left out of the electorate; it is not counted as a vote against. A word is accepted when strictly more than half of the copies that did arrive are identical in every bit. Three flags report the outcome: agreement, no majority, or nothing arrived.

Top module: `replica_voter`

## Requirements
- R1: Each of the three lanes captures the word present on its first valid strobe in a window, and that word takes part in the vote at close.
- R2: A lane with no arrival in the window is excluded from the vote; with copies {bad, good, good} or {absent, good, good} the result is the good word with `vote_ok` set.
- R3: With exactly two copies present and they differ, `no_major` is set, `vote_ok` is clear and `vote_data` is zero.
- R4: With no copy present at close, `all_absent` is set and `vote_ok` and `no_major` are clear.
- R5: With exactly one copy present, that word is accepted with `vote_ok` set.
- R6: After any close exactly one of `vote_ok`, `no_major`, `all_absent` is set, and `vote_data` is zero whenever `vote_ok` is clear.
- R7: The outputs take the decision on the clock edge where `win_close` is high, so they are visible one clock after the close cycle, and they hold unchanged until the next close.
- R8: A second or later valid strobe on a lane in the same window is ignored; the first word is kept.
- R9: A valid strobe in the same cycle as `win_close` belongs to the window being closed; every lane is empty again at the start of the next window.
- R10: With three copies present, any two identical copies win; three distinct copies give `no_major`.
- R11: After reset all outputs are zero until the first close.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rep0_vld | input | 1 | Copy arrives on lane 0 |
| rep0_data | input | W | Word on lane 0 |
| rep1_vld | input | 1 | Copy arrives on lane 1 |
| rep1_data | input | W | Word on lane 1 |
| rep2_vld | input | 1 | Copy arrives on lane 2 |
| rep2_data | input | W | Word on lane 2 |
| win_close | input | 1 | One-cycle end-of-window strobe |
| vote_data | output | W | Agreed word, zero when there is none |
| vote_ok | output | 1 | An agreed word was found |
| no_major | output | 1 | Copies present but no strict majority |
| all_absent | output | 1 | No copy arrived in the window |

## Verification
The vote is tried with unanimous copies, a single corrupted copy in each lane position, two disagreeing copies with the third missing, one lone copy, an empty window and three distinct copies. Together these separate counting a silent lane as a dissenting vote from leaving it out, and a true majority from picking an arbitrary copy. Repeated strobes carrying a different word show whether the first arrival is kept. A strobe that coincides with the close, followed by an empty window, shows whether that late copy counts and whether the lanes clear. Each result is read again one cycle later to confirm it holds.

// File: rtl/replica_voter.sv
module replica_voter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rep0_vld,
  input  logic [W-1:0] rep0_data,
  input  logic         rep1_vld,
  input  logic [W-1:0] rep1_data,
  input  logic         rep2_vld,
  input  logic [W-1:0] rep2_data,
  input  logic         win_close,
  output logic [W-1:0] vote_data,
  output logic         vote_ok,
  output logic         no_major,
  output logic         all_absent
);

  logic [2:0]   held;
  logic [W-1:0] h0, h1, h2;

  wire [2:0] arr  = {rep2_vld, rep1_vld, rep0_vld};
  wire [2:0] take = arr & ~held;
  wire [2:0] pres = held | arr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      h0   <= '0;
      h1   <= '0;
      h2   <= '0;
    end else begin
      if (take[0]) h0 <= rep0_data;
      if (take[1]) h1 <= rep1_data;
      if (take[2]) h2 <= rep2_data;
      held <= win_close ? 3'b000 : pres;
    end
  end

  wire [W-1:0] e0 = held[0] ? h0 : rep0_data;
  wire [W-1:0] e1 = held[1] ? h1 : rep1_data;
  wire [W-1:0] e2 = held[2] ? h2 : rep2_data;

  wire pair01 = pres[0] & pres[1] & (e0 == e1);
  wire pair02 = pres[0] & pres[2] & (e0 == e2);
  wire pair12 = pres[1] & pres[2] & (e1 == e2);

  wire [1:0] n_pres = 2'(pres[0]) + 2'(pres[1]) + 2'(pres[2]);

  logic         ok_c, nm_c, ab_c;
  logic [W-1:0] val_c;

  always_comb begin
    ok_c  = 1'b0;
    nm_c  = 1'b0;
    ab_c  = 1'b0;
    val_c = '0;
    case (n_pres)
      2'd0: ab_c = 1'b1;
      2'd1: begin
        ok_c  = 1'b1;
        val_c = pres[0] ? e0 : (pres[1] ? e1 : e2);
      end
      default: begin
        if (pair01 | pair02) begin
          ok_c  = 1'b1;
          val_c = e0;
        end else if (pair12) begin
          ok_c  = 1'b1;
          val_c = e1;
        end else begin
          nm_c = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vote_data  <= '0;
      vote_ok    <= 1'b0;
      no_major   <= 1'b0;
      all_absent <= 1'b0;
    end else if (win_close) begin
      vote_data  <= val_c;
      vote_ok    <= ok_c;
      no_major   <= nm_c;
      all_absent <= ab_c;
    end
  end

endmodule

// File: rtl/replica_voter_chk.sv
module replica_voter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rep0_vld,
  input logic         rep1_vld,
  input logic         rep2_vld,
  input logic         win_close,
  input logic [2:0]   held,
  input logic [W-1:0] h0,
  input logic [W-1:0] vote_data,
  input logic         vote_ok,
  input logic         no_major,
  input logic         all_absent
);

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vote_ok, no_major, all_absent}));

  a_r6_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    !vote_ok |-> vote_data == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> $stable({vote_data, vote_ok, no_major, all_absent}));

  a_r4_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && held == 3'b000 && !rep0_vld && !rep1_vld && !rep2_vld)
      |=> (all_absent && !vote_ok && !no_major));

  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held[0] && !win_close) |=> $stable(h0));

  a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> held == 3'b000);

endmodule

bind replica_voter replica_voter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rep0_vld(rep0_vld), .rep1_vld(rep1_vld), .rep2_vld(rep2_vld),
  .win_close(win_close), .held(held), .h0(h0),
  .vote_data(vote_data), .vote_ok(vote_ok),
  .no_major(no_major), .all_absent(all_absent)
);

// File: tb/replica_voter_tb.sv
module replica_voter_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rep0_vld = 0, rep1_vld = 0, rep2_vld = 0, win_close = 0;
  logic [W-1:0] rep0_data = '0, rep1_data = '0, rep2_data = '0;
  logic [W-1:0] vote_data;
  logic vote_ok, no_major, all_absent;

  always #5 clk = ~clk;

  replica_voter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rep0_vld(rep0_vld), .rep0_data(rep0_data),
    .rep1_vld(rep1_vld), .rep1_data(rep1_data),
    .rep2_vld(rep2_vld), .rep2_data(rep2_data),
    .win_close(win_close),
    .vote_data(vote_data), .vote_ok(vote_ok),
    .no_major(no_major), .all_absent(all_absent)
  );

  typedef struct {
    logic [W-1:0] d;
    logic ok, nm, ab;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic cmp(input string tag, input exp_t e);
    checks++;
    if (vote_data !== e.d || vote_ok !== e.ok || no_major !== e.nm || all_absent !== e.ab) begin
      errors++;
      $display("FAIL %s: got data=%h ok=%b nm=%b ab=%b expected data=%h ok=%b nm=%b ab=%b",
               tag, vote_data, vote_ok, no_major, all_absent, e.d, e.ok, e.nm, e.ab);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [W-1:0] d0,
                                 input logic [W-1:0] d1, input logic [W-1:0] d2,
                                 input string tag);
    exp_t r;
    logic [W-1:0] v [3];
    int n;
    v[0] = d0; v[1] = d1; v[2] = d2;
    r.d = '0; r.ok = 0; r.nm = 0; r.ab = 0; r.tag = tag;
    n = 0;
    for (int i = 0; i < 3; i++) if (m[i]) n++;
    if (n == 0) r.ab = 1;
    else begin
      for (int i = 0; i < 3; i++) begin
        int agree = 0;
        if (m[i]) begin
          for (int j = 0; j < 3; j++) if (m[j] && v[j] == v[i]) agree++;
          if (2 * agree > n && !r.ok) begin r.ok = 1; r.d = v[i]; end
        end
      end
      if (!r.ok) r.nm = 1;
    end
    return r;
  endfunction

  task automatic pulse(input int lane, input logic [W-1:0] d, input bit close);
    @(negedge clk);
    rep0_vld = (lane == 0); rep1_vld = (lane == 1); rep2_vld = (lane == 2);
    if (lane == 0) rep0_data = d;
    if (lane == 1) rep1_data = d;
    if (lane == 2) rep2_data = d;
    win_close = close;
  endtask

  // m: lanes present; dup: lanes that get a later differing strobe; late2: lane 2 arrives with the close
  task automatic window(input logic [2:0] m, input logic [W-1:0] d0, input logic [W-1:0] d1,
                        input logic [W-1:0] d2, input logic [2:0] dup, input bit late2,
                        input string tag);
    logic [W-1:0] v [3];
    v[0] = d0; v[1] = d1; v[2] = d2;
    for (int i = 0; i < 3; i++)
      if (m[i] && !(i == 2 && late2)) pulse(i, v[i], 1'b0);
    for (int i = 0; i < 3; i++)
      if (m[i] && dup[i] && !(i == 2 && late2)) pulse(i, ~v[i], 1'b0);
    sb.push_back(model(m, d0, d1, d2, tag));
    pulse((late2 && m[2]) ? 2 : 3, d2, 1'b1);
    @(negedge clk);
    rep0_vld = 0; rep1_vld = 0; rep2_vld = 0; win_close = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (win_close && rst_n) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: result without a pending window, got ok=%b expected none", vote_ok);
        end else begin
          e = sb.pop_front();
          cmp(e.tag, e);
          @(negedge clk);
          cmp({e.tag, " R7 hold"}, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z.d = '0; z.ok = 0; z.nm = 0; z.ab = 0; z.tag = "R11";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R11 reset state", z);
    repeat (3) @(negedge clk);
    cmp("R11 idle before first close", z);

    window(3'b111, 16'h0005, 16'h0005, 16'h0005, 3'b000, 0, "R1 R10 unanimous");
    window(3'b111, 16'hBAD0, 16'h0005, 16'h0005, 3'b000, 0, "R2 bad lane0");
    window(3'b111, 16'h1234, 16'hBAD1, 16'h1234, 3'b000, 0, "R2 bad lane1");
    window(3'b111, 16'h7777, 16'h7777, 16'hBAD2, 3'b000, 0, "R10 bad lane2");
    window(3'b011, 16'h00AA, 16'h0055, 16'h0000, 3'b000, 0, "R3 two differ");
    window(3'b110, 16'h0000, 16'h4242, 16'h4242, 3'b000, 0, "R2 absent plus two good");
    window(3'b101, 16'h0001, 16'h0000, 16'h0003, 3'b000, 0, "R3 R6 lanes 0 2 differ");
    window(3'b000, 16'h0000, 16'h0000, 16'h0000, 3'b000, 0, "R4 empty");
    window(3'b010, 16'h0000, 16'hC0DE, 16'h0000, 3'b000, 0, "R5 single copy");
    window(3'b111, 16'h0011, 16'h0022, 16'h0033, 3'b000, 0, "R10 three distinct");
    window(3'b111, 16'h5A5A, 16'h5A5A, 16'h0F0F, 3'b011, 0, "R8 repeated strobes ignored");
    window(3'b001, 16'h0099, 16'h0000, 16'h0000, 3'b001, 0, "R8 R5 lone copy first kept");
    window(3'b100, 16'h0000, 16'h0000, 16'hFEED, 3'b000, 1, "R9 arrival with close");
    window(3'b111, 16'h3333, 16'h4444, 16'h3333, 3'b000, 1, "R9 late copy breaks tie");
    window(3'b000, 16'h0000, 16'h0000, 16'h0000, 3'b000, 0, "R9 lanes cleared");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule